// File: doc/BRIEF.md
# Class-of-Service Way Mask Controller

This block keeps a table of cache capacity masks, one for each class of service, and turns the active class of a hardware thread into an allowed-ways mask for a shared cache. It holds two independent tables that serve two cache levels. Both tables are indexed by the same class number, and each table can implement a different number of classes and a different mask width. Software reaches every register through a simple one-cycle address/data request bus. The response (read data, read-valid, error) appears one clock after the request.

A separate association register holds the active class. Software rewrites it on each context switch. Both way outputs are read straight from the stored state, so they follow a write on the clock edge that takes that write. A mask write is accepted only if its set bits form a single run. A class number beyond what a table implements does not fault. That table then grants every way.

Top module: `cos_mask_ctrl`

## Requirements
- R1: After reset every mask entry of both tables is all ones, the active class is 0 (so both way outputs are all ones), and `err` and `rd_valid` are low.
- R2: Level-A entry n sits at address BASE_A+n (default 0xD10+n, 16 entries of 16 bits); level-B entry n sits at BASE_B+n (default 0xC90+n, 8 entries of 12 bits). A read returns the stored mask, zero-extended, on `rd_data` with `rd_valid` high one cycle after the request.
- R3: A write whose low mask-width bits are a non-zero single contiguous run of ones, with all higher data bits zero, replaces the addressed entry.
- R4: A mask write that is zero, has a gap between set bits, or sets a bit above the mask width is dropped, and the old value is kept. `err` is high for exactly the cycle after that request.
- R5: A write to the association address (default 0xC8F) loads the active class from data bits [7:0] and ignores the other bits. Reading that address returns the class in bits [7:0] with zeros above.
- R6: While the active class is implemented by a table, that table's way output equals the entry for that class. The output reflects a write to the association register, or to the selected entry, from the clock edge that takes the write.
- R7: If the active class is at or above a table's entry count, that table's way output is all ones. Each table applies this rule on its own.
- R8: A request to any other address raises `err` for the following cycle. A read there returns zero, and a write there changes nothing.
- R9: A write to one table never alters the other table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Register address |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read response valid (one cycle after request) |
| rd_data | output | 32 | Read response data |
| err | output | 1 | One-cycle pulse for a rejected or unmapped request |
| ways_a | output | MASK_W_A | Allowed-ways mask for the level-A cache |
| ways_b | output | MASK_W_B | Allowed-ways mask for the level-B cache |

## Verification
A mask write can land on the entry that the active class currently selects. In that same cycle the write must reach the way output, unless the write is rejected. The bench provokes this on purpose: it sets the class, then rewrites that class's entry with good and bad data. It judges the way output right after that edge against a bench model that commits only accepted data. Association writes that cross a table's entry count are interleaved with mask writes in the random phase, so that the per-table out-of-range rule is judged in the same cycles that the tables change.

// File: rtl/cos_mask_pkg.sv
package cos_mask_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned COS_W  = 8;

  // True when v is non-zero and its set bits form one unbroken run.
  function automatic logic is_run(input logic [63:0] v);
    logic [63:0] filled;
    filled = v | (v - 64'd1);
    return (v != 64'd0) && ((filled & (filled + 64'd1)) == 64'd0);
  endfunction
endpackage

// File: rtl/cos_assoc_reg.sv
module cos_assoc_reg
  import cos_mask_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [COS_W-1:0] cos_q
);
  logic [COS_W-1:0] cos_d;

  always_comb begin
    cos_d = cos_q;
    if (wr_en) cos_d = wdata[COS_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cos_q <= '0;
    else if (wr_en) cos_q <= cos_d;
  end

  AST_ASSOC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cos_q == $past(wdata[COS_W-1:0])); // R5
endmodule

// File: rtl/cos_mask_table.sv
module cos_mask_table
  import cos_mask_pkg::*;
#(
  parameter int unsigned NUM  = 16,
  parameter int unsigned W    = 16,
  parameter int unsigned BASE = 32'hD10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wdata,
  input  logic [COS_W-1:0]  cos_sel,
  output logic              hit,
  output logic              wr_reject,
  output logic [DATA_W-1:0] rd_mask,
  output logic [W-1:0]      ways
);
  localparam int unsigned IDX_W = (NUM > 1) ? $clog2(NUM) : 1;

  logic [NUM-1:0][W-1:0] mask_q;
  logic [NUM-1:0][W-1:0] mask_d;
  logic [NUM-1:0]        ent_en;
  logic [31:0]           offset;
  logic [IDX_W-1:0]      idx;
  logic [IDX_W-1:0]      sel_idx;
  logic                  data_ok;
  logic                  upper_clear;
  logic                  wr_accept;
  logic                  sel_in_range;

  always_comb begin
    offset = 32'(addr) - BASE;
    hit    = (32'(addr) >= BASE) && (offset < NUM);
    idx    = offset[IDX_W-1:0];
  end

  generate
    if (W < DATA_W) begin : g_upper
      assign upper_clear = (wdata[DATA_W-1:W] == '0);
    end else begin : g_noupper
      assign upper_clear = 1'b1;
    end
  endgenerate

  assign data_ok   = is_run(64'(wdata[W-1:0])) && upper_clear;
  assign wr_accept = wr_req && hit && data_ok;
  assign wr_reject = wr_req && hit && !data_ok;

  generate
    for (genvar i = 0; i < NUM; i++) begin : g_ent
      assign ent_en[i] = wr_accept && (idx == IDX_W'(i));

      always_comb begin
        mask_d[i] = mask_q[i];
        if (ent_en[i]) mask_d[i] = wdata[W-1:0];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         mask_q[i] <= '1;
        else if (ent_en[i]) mask_q[i] <= mask_d[i];
      end

      AST_STORED_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
        is_run(64'(mask_q[i]))); // R3
    end
  endgenerate

  always_comb begin
    rd_mask = '0;
    if (hit) rd_mask = DATA_W'(mask_q[idx]);
  end

  assign sel_in_range = (32'(cos_sel) < NUM);
  assign sel_idx      = cos_sel[IDX_W-1:0];

  always_comb begin
    ways = '1;
    if (sel_in_range) ways = mask_q[sel_idx];
  end

  AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |=> $stable(mask_q)); // R4
endmodule

// File: rtl/cos_mask_ctrl.sv
module cos_mask_ctrl
  import cos_mask_pkg::*;
#(
  parameter int unsigned NUM_A      = 16,
  parameter int unsigned MASK_W_A   = 16,
  parameter int unsigned BASE_A     = 32'hD10,
  parameter int unsigned NUM_B      = 8,
  parameter int unsigned MASK_W_B   = 12,
  parameter int unsigned BASE_B     = 32'hC90,
  parameter int unsigned ASSOC_ADDR = 32'hC8F
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [11:0]         req_addr,
  input  logic [31:0]         req_wdata,
  output logic                rd_valid,
  output logic [31:0]         rd_data,
  output logic                err,
  output logic [MASK_W_A-1:0] ways_a,
  output logic [MASK_W_B-1:0] ways_b
);
  logic [1:0]        rst_sync_q;
  logic              rst_n_i;
  logic              wr_req;
  logic              hit_a, hit_b, hit_assoc, any_hit;
  logic              rej_a, rej_b;
  logic [DATA_W-1:0] rd_a, rd_b;
  logic [COS_W-1:0]  cos_q;
  logic              err_d, rdv_d;
  logic [DATA_W-1:0] rdat_d;
  logic              err_q, rdv_q;
  logic [DATA_W-1:0] rdat_q;

  // reset: asserted at once, released after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  assign wr_req    = req_valid && req_write;
  assign hit_assoc = (32'(req_addr) == ASSOC_ADDR);

  cos_assoc_reg u_assoc (
    .clk   (clk),
    .rst_n (rst_n_i),
    .wr_en (wr_req && hit_assoc),
    .wdata (req_wdata),
    .cos_q (cos_q)
  );

  cos_mask_table #(.NUM(NUM_A), .W(MASK_W_A), .BASE(BASE_A)) u_tab_a (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .addr      (req_addr),
    .wr_req    (wr_req),
    .wdata     (req_wdata),
    .cos_sel   (cos_q),
    .hit       (hit_a),
    .wr_reject (rej_a),
    .rd_mask   (rd_a),
    .ways      (ways_a)
  );

  cos_mask_table #(.NUM(NUM_B), .W(MASK_W_B), .BASE(BASE_B)) u_tab_b (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .addr      (req_addr),
    .wr_req    (wr_req),
    .wdata     (req_wdata),
    .cos_sel   (cos_q),
    .hit       (hit_b),
    .wr_reject (rej_b),
    .rd_mask   (rd_b),
    .ways      (ways_b)
  );

  assign any_hit = hit_a || hit_b || hit_assoc;

  always_comb begin
    err_d  = req_valid && (!any_hit || rej_a || rej_b);
    rdv_d  = req_valid && !req_write;
    rdat_d = '0;
    if (hit_assoc)  rdat_d = DATA_W'(cos_q);
    else if (hit_a) rdat_d = rd_a;
    else if (hit_b) rdat_d = rd_b;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      err_q <= 1'b0;
      rdv_q <= 1'b0;
    end else begin
      err_q <= err_d;
      rdv_q <= rdv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)   rdat_q <= '0;
    else if (rdv_d) rdat_q <= rdat_d;
  end

  assign err      = err_q;
  assign rd_valid = rdv_q;
  assign rd_data  = rdat_q;

  AST_UNMAPPED_ERR: assert property (@(posedge clk) disable iff (!rst_n_i)
    (req_valid && !any_hit) |=> err); // R8

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n_i)
    (req_valid && !req_write && !any_hit) |=> (rd_valid && rd_data == '0)); // R8

  AST_OOR_OPEN_A: assert property (@(posedge clk) disable iff (!rst_n_i)
    (wr_req && hit_assoc && (32'(req_wdata[COS_W-1:0]) >= NUM_A)) |=> (&ways_a)); // R7

  AST_OOR_OPEN_B: assert property (@(posedge clk) disable iff (!rst_n_i)
    (wr_req && hit_assoc && (32'(req_wdata[COS_W-1:0]) >= NUM_B)) |=> (&ways_b)); // R7
endmodule

// File: tb/tb_cos_mask_ctrl.sv
module tb_cos_mask_ctrl;
  localparam time CLK_PERIOD = 10ns;
  localparam int NA = 16, WA = 16, NB = 8, WB = 12;
  localparam int BA = 'hD10, BB = 'hC90, AS = 'hC8F;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_write;
  logic [11:0] req_addr;
  logic [31:0] req_wdata;
  logic rd_valid, err;
  logic [31:0] rd_data;
  logic [WA-1:0] ways_a;
  logic [WB-1:0] ways_b;

  int total = 0, bad = 0;
  logic [WA-1:0] ref_a [NA];
  logic [WB-1:0] ref_b [NB];
  int ref_cos;
  logic s_err, s_rdv;
  logic [31:0] s_rdata;

  cos_mask_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .err(err), .ways_a(ways_a), .ways_b(ways_b));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit contig(input logic [63:0] v, input int w);
    int first, last, cnt;
    if (w < 64 && (v >> w) != 0) return 0;
    first = -1; last = -1; cnt = 0;
    for (int i = 0; i < 64; i++)
      if (v[i]) begin if (first < 0) first = i; last = i; cnt++; end
    return (cnt > 0) && (last - first + 1 == cnt);
  endfunction

  function automatic logic [31:0] rand_run(input int w);
    int len, lo;
    len = 1 + int'($urandom % w);
    lo  = int'($urandom % (w - len + 1));
    return 32'(((64'd1 << len) - 64'd1) << lo);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input bit wr, input int addr, input logic [31:0] data);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = 12'(addr); req_wdata = data;
    @(negedge clk);
    s_err = err; s_rdv = rd_valid; s_rdata = rd_data;
    req_valid = 1'b0;
  endtask

  // Applies one request to the model and checks response and outputs.
  task automatic op(input bit wr, input int addr, input logic [31:0] data);
    bit exp_err;
    logic [31:0] exp_rd;
    logic [WA-1:0] ea;
    logic [WB-1:0] eb;
    exp_err = 1'b0; exp_rd = '0;
    if (addr == AS) begin
      if (wr) ref_cos = int'(data[7:0]); else exp_rd = 32'(ref_cos);
    end else if (addr >= BA && addr < BA + NA) begin
      if (wr) begin
        if (contig(64'(data), WA)) ref_a[addr-BA] = data[WA-1:0]; else exp_err = 1'b1;
      end else exp_rd = 32'(ref_a[addr-BA]);
    end else if (addr >= BB && addr < BB + NB) begin
      if (wr) begin
        if (contig(64'(data), WB)) ref_b[addr-BB] = data[WB-1:0]; else exp_err = 1'b1;
      end else exp_rd = 32'(ref_b[addr-BB]);
    end else exp_err = 1'b1;
    bus(wr, addr, data);
    chk(s_err == exp_err, "R4/R8 err", 32'(s_err), 32'(exp_err));
    chk(s_rdv == !wr, "R2 rd_valid", 32'(s_rdv), 32'(!wr));
    if (!wr) chk(s_rdata == exp_rd, "R2/R5/R8 rd_data", s_rdata, exp_rd);
    ea = (ref_cos < NA) ? ref_a[ref_cos] : '1;
    eb = (ref_cos < NB) ? ref_b[ref_cos] : '1;
    chk(ways_a == ea, "R6/R7 ways_a", 32'(ways_a), 32'(ea));
    chk(ways_b == eb, "R6/R7/R9 ways_b", 32'(ways_b), 32'(eb));
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    for (int i = 0; i < NA; i++) ref_a[i] = '1;
    for (int i = 0; i < NB; i++) ref_b[i] = '1;
    ref_cos = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(ways_a == '1, "R1 ways_a", 32'(ways_a), 32'hFFFF);
    chk(ways_b == '1, "R1 ways_b", 32'(ways_b), 32'hFFF);
    chk(!err && !rd_valid, "R1 err/rd_valid", {30'b0, err, rd_valid}, 0);
    op(0, BA + 15, 0);               // R1 R2 last A entry all ones
    op(0, BB + 7, 0);                // R1 R2
    op(0, AS, 0);                    // R1 R5 class 0

    // R3 R6: rewrite the selected entry (class 0)
    op(1, BA, 32'h0000_00F0);
    op(1, BB, 32'h0000_0F00);
    // R4: gap, zero, bit above width on the selected entry
    op(1, BA, 32'h0000_0101);
    op(1, BA, 32'h0);
    op(1, BA, 32'h0001_0000);
    op(1, BB, 32'h0000_1000);        // R4 bit 12 above B width
    op(0, BA, 0);
    // R9: write A entry 3, B entry 3 unchanged
    op(1, BA + 3, 32'h0000_FFFF);
    op(0, BB + 3, 0);
    // R5 upper bits ignored; R7 boundaries
    op(1, AS, 32'hABCD_0007);        // class 7: both implemented
    op(1, BB + 7, 32'h0000_0003);
    op(1, AS, 32'h0000_0008);        // B out of range, A in range
    op(0, AS, 0);
    op(1, AS, 32'h0000_000F);
    op(1, AS, 32'h0000_0010);        // A out of range too
    op(1, AS, 32'h0000_00FF);
    // R8 unmapped
    op(0, BA + NA, 0);
    op(1, BA + NA, 32'h1);
    op(1, BB + NB, 32'h1);
    op(0, BB - 2, 0);
    op(1, AS, 32'h0);

    // random phase
    for (int n = 0; n < 600; n++) begin
      int kind, a;
      logic [31:0] d;
      kind = int'($urandom % 5);
      case (kind)
        0: op(1, AS, {$urandom, 8'h00} | 32'($urandom % 20));
        1: begin
          a = BA + int'($urandom % (NA + 2));
          d = ($urandom % 4 != 0) ? rand_run(WA) : $urandom & 32'h0001_FFFF;
          op(1, a, d);
        end
        2: begin
          a = BB + int'($urandom % (NB + 2));
          d = ($urandom % 4 != 0) ? rand_run(WB) : $urandom & 32'h0000_1FFF;
          op(1, a, d);
        end
        3: begin
          d = rand_run(WA);
          op(1, AS, 32'($urandom % NA));
          op(1, BA + ref_cos, d);    // R6 write to selected entry
        end
        default: begin
          case ($urandom % 4)
            0: a = AS;
            1: a = BA + int'($urandom % (NA + 2));
            2: a = BB + int'($urandom % (NB + 2));
            default: a = int'($urandom % 4096);
          endcase
          op(0, a, 0);
        end
      endcase
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule